// File: doc/BRIEF.md
# Three-Register Evaluation Stack Datapath

This block executes already-decoded instructions against a three-entry register stack named A (top), B and C. There are no register-file indices. Each instruction's sources and destinations are implied by its function code. Values move between the three entries through fixed push and pop shuffles. A workspace pointer, set from a parameter at reset, serves as the base for local-variable memory accesses. The A register serves as the base for non-local accesses, so a program can follow pointers into data structures.

An instruction decoder presents a function code, a 32-bit operand and an issue strobe. The block drives a single-port word memory through an address, write data, a write strobe and a read request. A read holds `busy_o` high until the word has returned, and issues presented during that time are dropped. Writes finish in the issue cycle and do not raise `busy_o`. The three stack entries are visible as outputs so that neighbouring logic can consume results.

Top module: `evalstack_core`

## Requirements
- R1: While reset is asserted and right after it is released, A, B and C are zero, `busy_o` is low, and `mem_req_o` and `mem_we_o` are low.
- R2: Function code 1 (load constant) accepted with `busy_o` low pushes the stack: on the next cycle A holds the operand, B holds the old A and C holds the old B. The access takes no memory cycle.
- R3: Function code 2 (load local) issues a read at the workspace pointer plus 4 times the operand. `mem_req_o` is high for the one cycle after acceptance, and `busy_o` is high for two cycles. In the cycle after that, the returned word is pushed exactly as in R2.
- R4: Function code 3 (store local) raises `mem_we_o` for one cycle with the workspace pointer plus 4 times the operand as the address and the old A as the data. In the same step A takes B, B takes C, and C is unchanged.
- R5: Function code 4 (load non-local) reads at A plus 4 times the operand, with the same timing as R3. The returned word replaces A, and B and C are unchanged.
- R6: Function code 5 (store non-local) writes the old B to A plus 4 times the operand for one cycle. Afterwards both A and B hold the old C, and C is unchanged.
- R7: Function code 6 (operate) with operand 0 leaves B+A in A, and with operand 1 leaves B−A in A. In both cases B takes C and C is unchanged.
- R8: Operate with operand 2, 3 or 4 leaves B AND A, B OR A or B XOR A in A, with B taking C. Operand 5 exchanges A and B. C is unchanged in all of these.
- R9: Issues presented while `busy_o` is high, function codes 0 and 7 to 15, and operate operands of 6 or more all leave A, B and C unchanged and start no memory access.
- R10: Sums, differences and addresses wrap modulo 2^32. The operand is a two's-complement word offset, so a negative operand addresses below the base.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| issue_i | input | 1 | Decoded instruction valid |
| func_i | input | 4 | Function code |
| operand_i | input | 32 | Operand, word offset or constant or operation code |
| mem_addr_o | output | 32 | Byte address of the memory word |
| mem_wdata_o | output | 32 | Write data |
| mem_we_o | output | 1 | Write strobe, one cycle |
| mem_req_o | output | 1 | Read request, one cycle |
| mem_rdata_i | input | 32 | Read data, valid the cycle after the request |
| busy_o | output | 1 | Read outstanding, issues ignored |
| a_o | output | 32 | Stack top A |
| b_o | output | 32 | Stack entry B |
| c_o | output | 32 | Stack entry C |

## Verification
Load constant is swept over every single-nibble operand and over some wide values. This separates a correct push from a shuffle that drops or duplicates an entry. Each operate code runs over all ordered pairs from a set of edge values (zero, one, the sign boundaries, all ones and a mixed pattern). The ordered pairs expose swapped operands in subtraction and missed wrap-around in addition. Local loads and stores sweep offsets from −1 to 15, and non-local accesses use bases near the top of the address space. Together these show whether the base is the workspace pointer or A, and whether offsets are scaled to words. Issues during a read, unused function codes and out-of-range operate codes are applied and must change nothing.

// File: rtl/evs_pkg.sv
package evs_pkg;
  localparam logic [3:0] FN_LDC  = 4'd1;
  localparam logic [3:0] FN_LDL  = 4'd2;
  localparam logic [3:0] FN_STL  = 4'd3;
  localparam logic [3:0] FN_LDNL = 4'd4;
  localparam logic [3:0] FN_STNL = 4'd5;
  localparam logic [3:0] FN_OPR  = 4'd6;

  localparam int unsigned NUM_SEC = 6;
  localparam logic [2:0] SEC_ADD  = 3'd0;
  localparam logic [2:0] SEC_SUB  = 3'd1;
  localparam logic [2:0] SEC_AND  = 3'd2;
  localparam logic [2:0] SEC_OR   = 3'd3;
  localparam logic [2:0] SEC_XOR  = 3'd4;
  localparam logic [2:0] SEC_SWAP = 3'd5;

  typedef enum logic [2:0] {
    STK_HOLD, STK_PUSH, STK_POP, STK_REPL, STK_POP2, STK_SWAP
  } stk_cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE, ST_RD_REQ, ST_RD_WAIT
  } st_e;
endpackage

// File: rtl/evs_agen.sv
module evs_agen #(
  parameter int DW = 32,
  parameter int AW = 32
) (
  input  logic [AW-1:0] base_i,
  input  logic [DW-1:0] off_i,
  output logic [AW-1:0] addr_o
);
  localparam int SHIFT = 2;
  logic [AW-1:0] off_w;
  // sign-extend or truncate the word offset to the address width
  generate
    if (AW > DW) begin : g_ext
      assign off_w = {{(AW-DW){off_i[DW-1]}}, off_i};
    end else begin : g_trunc
      assign off_w = off_i[AW-1:0];
    end
  endgenerate
  assign addr_o = base_i + {off_w[AW-SHIFT-1:0], {SHIFT{1'b0}}};
endmodule

// File: rtl/evs_alu.sv
module evs_alu #(
  parameter int DW = 32
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic [2:0]    sel_i,
  output logic [DW-1:0] res_o
);
  import evs_pkg::*;
  always_comb begin
    unique case (sel_i)
      SEC_ADD: res_o = b_i + a_i;
      SEC_SUB: res_o = b_i - a_i;
      SEC_AND: res_o = b_i & a_i;
      SEC_OR:  res_o = b_i | a_i;
      SEC_XOR: res_o = b_i ^ a_i;
      default: res_o = b_i;
    endcase
  end
endmodule

// File: rtl/evs_stack.sv
module evs_stack #(
  parameter int DW = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  evs_pkg::stk_cmd_e   cmd_i,
  input  logic [DW-1:0]       val_i,
  output logic [DW-1:0]       a_o,
  output logic [DW-1:0]       b_o,
  output logic [DW-1:0]       c_o
);
  import evs_pkg::*;
  logic [DW-1:0] a_q, b_q, c_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q <= '0;
      b_q <= '0;
      c_q <= '0;
    end else begin
      unique case (cmd_i)
        STK_PUSH: begin c_q <= b_q; b_q <= a_q; a_q <= val_i; end
        STK_POP:  begin a_q <= val_i; b_q <= c_q; end
        STK_REPL: a_q <= val_i;
        STK_POP2: begin a_q <= c_q; b_q <= c_q; end
        STK_SWAP: begin a_q <= b_q; b_q <= a_q; end
        default: ;
      endcase
    end
  end

  assign a_o = a_q;
  assign b_o = b_q;
  assign c_o = c_q;
endmodule

// File: rtl/evs_ctrl.sv
module evs_ctrl #(
  parameter int DW = 32,
  parameter int AW = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              issue_i,
  input  logic [3:0]        func_i,
  input  logic [DW-1:0]     operand_i,
  input  logic [DW-1:0]     a_i,
  input  logic [DW-1:0]     b_i,
  input  logic [AW-1:0]     wptr_i,
  input  logic [DW-1:0]     rdata_i,
  input  logic [DW-1:0]     alu_res_i,
  input  logic [AW-1:0]     agen_addr_i,
  output logic [AW-1:0]     agen_base_o,
  output logic [2:0]        alu_sel_o,
  output evs_pkg::stk_cmd_e stk_cmd_o,
  output logic [DW-1:0]     stk_val_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic [DW-1:0]     mem_wdata_o,
  output logic              mem_we_o,
  output logic              mem_req_o,
  output logic              busy_o
);
  import evs_pkg::*;

  st_e           state_q;
  logic          push_q;
  logic          accept;
  logic          sec_ok;
  logic          is_nl;
  logic          do_rd, do_wr;
  logic [DW-1:0] wdata_d;

  assign accept    = issue_i && (state_q == ST_IDLE);
  assign sec_ok    = (operand_i < DW'(NUM_SEC));
  assign alu_sel_o = operand_i[2:0];
  assign is_nl     = (func_i == FN_LDNL) || (func_i == FN_STNL);
  assign agen_base_o = is_nl ? a_i[AW-1:0] : wptr_i;

  always_comb begin
    stk_cmd_o = STK_HOLD;
    stk_val_o = rdata_i;
    do_rd     = 1'b0;
    do_wr     = 1'b0;
    wdata_d   = a_i;
    if (state_q == ST_RD_WAIT) begin
      stk_cmd_o = push_q ? STK_PUSH : STK_REPL;
    end else if (accept) begin
      unique case (func_i)
        FN_LDC: begin stk_cmd_o = STK_PUSH; stk_val_o = operand_i; end
        FN_LDL, FN_LDNL: do_rd = 1'b1;
        FN_STL: begin
          do_wr = 1'b1; wdata_d = a_i;
          stk_cmd_o = STK_POP; stk_val_o = b_i;
        end
        FN_STNL: begin
          do_wr = 1'b1; wdata_d = b_i;
          stk_cmd_o = STK_POP2;
        end
        FN_OPR: if (sec_ok) begin
          if (alu_sel_o == SEC_SWAP) stk_cmd_o = STK_SWAP;
          else begin stk_cmd_o = STK_POP; stk_val_o = alu_res_i; end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      push_q      <= 1'b0;
      mem_addr_o  <= '0;
      mem_wdata_o <= '0;
      mem_we_o    <= 1'b0;
      mem_req_o   <= 1'b0;
    end else begin
      mem_we_o  <= do_wr;
      mem_req_o <= do_rd;
      if (do_rd || do_wr) mem_addr_o <= agen_addr_i;
      if (do_wr) mem_wdata_o <= wdata_d;
      unique case (state_q)
        ST_IDLE: if (do_rd) begin
          state_q <= ST_RD_REQ;
          push_q  <= (func_i == FN_LDL);
        end
        ST_RD_REQ:  state_q <= ST_RD_WAIT;
        default:    state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = (state_q != ST_IDLE);
endmodule

// File: rtl/evalstack_core.sv
module evalstack_core #(
  parameter int          DW       = 32,
  parameter int          AW       = 32,
  parameter logic [31:0] WS_RESET = 32'h0000_0100
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          issue_i,
  input  logic [3:0]    func_i,
  input  logic [DW-1:0] operand_i,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  output logic          mem_we_o,
  output logic          mem_req_o,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          busy_o,
  output logic [DW-1:0] a_o,
  output logic [DW-1:0] b_o,
  output logic [DW-1:0] c_o
);
  import evs_pkg::*;

  logic [AW-1:0] wptr_q;
  logic [AW-1:0] agen_base, agen_addr;
  logic [2:0]    alu_sel;
  logic [DW-1:0] alu_res;
  stk_cmd_e      stk_cmd;
  logic [DW-1:0] stk_val;

  // workspace pointer: loaded at reset, held thereafter
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wptr_q <= AW'(WS_RESET);
    else         wptr_q <= wptr_q;
  end

  evs_stack #(.DW(DW)) u_stack (
    .clk_i (clk_i), .rst_ni(rst_ni), .cmd_i(stk_cmd), .val_i(stk_val),
    .a_o   (a_o),   .b_o   (b_o),    .c_o  (c_o)
  );

  evs_alu #(.DW(DW)) u_alu (
    .a_i(a_o), .b_i(b_o), .sel_i(alu_sel), .res_o(alu_res)
  );

  evs_agen #(.DW(DW), .AW(AW)) u_agen (
    .base_i(agen_base), .off_i(operand_i), .addr_o(agen_addr)
  );

  evs_ctrl #(.DW(DW), .AW(AW)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .issue_i     (issue_i),
    .func_i      (func_i),
    .operand_i   (operand_i),
    .a_i         (a_o),
    .b_i         (b_o),
    .wptr_i      (wptr_q),
    .rdata_i     (mem_rdata_i),
    .alu_res_i   (alu_res),
    .agen_addr_i (agen_addr),
    .agen_base_o (agen_base),
    .alu_sel_o   (alu_sel),
    .stk_cmd_o   (stk_cmd),
    .stk_val_o   (stk_val),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .mem_we_o    (mem_we_o),
    .mem_req_o   (mem_req_o),
    .busy_o      (busy_o)
  );
endmodule

// File: rtl/evs_chk.sv
module evs_chk #(
  parameter int DW = 32,
  parameter int AW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          issue_i,
  input logic [3:0]    func_i,
  input logic [DW-1:0] operand_i,
  input logic          mem_we_o,
  input logic          mem_req_o,
  input logic [DW-1:0] mem_wdata_o,
  input logic          busy_o,
  input logic [DW-1:0] a_o,
  input logic [DW-1:0] b_o,
  input logic [DW-1:0] c_o
);
  import evs_pkg::*;

  // R1: outputs idle while in reset
  always @(posedge clk_i)
    if (!rst_ni) a_r1_reset_idle: assert (!busy_o && !mem_req_o && !mem_we_o && a_o == '0);

  a_r2_push: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_i && !busy_o && func_i == FN_LDC) |=>
      (a_o == $past(operand_i) && b_o == $past(a_o) && c_o == $past(b_o)));

  a_r3_req_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> busy_o);

  a_r3_req_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> (!mem_req_o && busy_o));

  a_r4_store_pop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_i && !busy_o && func_i == FN_STL) |=>
      (mem_we_o && mem_wdata_o == $past(a_o) && a_o == $past(b_o) && c_o == $past(c_o)));

  a_r9_no_rw_overlap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_we_o && mem_req_o));

  a_r9_frozen_in_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> ($stable(a_o) && $stable(b_o) && $stable(c_o)));
endmodule

bind evalstack_core evs_chk #(.DW(DW), .AW(AW)) u_evs_chk (.*);

// File: tb/tb_evalstack_core.sv
module tb_evalstack_core;
  localparam logic [31:0] WS = 32'h0000_0100;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        issue = 1'b0;
  logic [3:0]  func = '0;
  logic [31:0] operand = '0;
  logic [31:0] mem_addr, mem_wdata, a, b, c;
  logic [31:0] rdata = '0;
  logic        mem_we, mem_req, busy;

  int checks = 0;
  int errors = 0;
  logic [31:0] ma = '0, mb = '0, mc = '0;
  logic [31:0] mem [64];

  always #10 clk = ~clk;

  evalstack_core #(.WS_RESET(WS)) dut (
    .clk_i(clk), .rst_ni(rst_n), .issue_i(issue), .func_i(func), .operand_i(operand),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_we_o(mem_we), .mem_req_o(mem_req),
    .mem_rdata_i(rdata), .busy_o(busy), .a_o(a), .b_o(b), .c_o(c)
  );

  always @(posedge clk) begin
    if (mem_req) rdata <= mem[mem_addr[7:2]];
    if (mem_we)  mem[mem_addr[7:2]] <= mem_wdata;
  end

  task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s act=%h exp=%h", rq, what, act, exp);
    end
  endtask

  task automatic chk_stack(input string rq);
    chk(rq, "A", a, ma);
    chk(rq, "B", b, mb);
    chk(rq, "C", c, mc);
  endtask

  // kind: 0 no access, 1 read+push, 2 read+replace, 3 write
  task automatic do_op(input logic [3:0] f, input logic [31:0] op, input string rq);
    logic [31:0] na, nb, nc, ea, ewd;
    int kind;
    na = ma; nb = mb; nc = mc; ea = '0; ewd = '0; kind = 0;
    case (f)
      4'd1: begin nc = mb; nb = ma; na = op; end
      4'd2: begin ea = WS + (op << 2); kind = 1; end
      4'd3: begin ea = WS + (op << 2); ewd = ma; kind = 3; na = mb; nb = mc; end
      4'd4: begin ea = ma + (op << 2); kind = 2; end
      4'd5: begin ea = ma + (op << 2); ewd = mb; kind = 3; na = mc; nb = mc; end
      4'd6: if (op < 6) begin
        case (op[2:0])
          3'd0: na = mb + ma;
          3'd1: na = mb - ma;
          3'd2: na = mb & ma;
          3'd3: na = mb | ma;
          3'd4: na = mb ^ ma;
          default: begin na = mb; nb = ma; end
        endcase
        if (op < 5) nb = mc;
      end
      default: ;
    endcase
    @(negedge clk);
    func = f; operand = op; issue = 1'b1;
    @(negedge clk);
    issue = 1'b0;
    if (kind == 1 || kind == 2) begin
      chk(rq, "req", {31'd0, mem_req}, 32'd1);
      chk(rq, "busy1", {31'd0, busy}, 32'd1);
      chk(rq, "raddr", mem_addr, ea);
      @(negedge clk);
      chk(rq, "busy2", {31'd0, busy}, 32'd1);
      chk(rq, "req_off", {31'd0, mem_req}, 32'd0);
      @(negedge clk);
      chk(rq, "busy_end", {31'd0, busy}, 32'd0);
      if (kind == 1) begin nc = mb; nb = ma; na = mem[ea[7:2]]; end
      else na = mem[ea[7:2]];
    end else if (kind == 3) begin
      chk(rq, "we", {31'd0, mem_we}, 32'd1);
      chk(rq, "waddr", mem_addr, ea);
      chk(rq, "wdata", mem_wdata, ewd);
      chk(rq, "busy", {31'd0, busy}, 32'd0);
    end else begin
      chk(rq, "no_access", {30'd0, mem_we, mem_req}, 32'd0);
    end
    ma = na; mb = nb; mc = nc;
    chk_stack(rq);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog act=%0d exp=%0d", checks, -1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] vals [6];
    logic [31:0] sa, sb;
    vals[0] = 32'h0; vals[1] = 32'h1; vals[2] = 32'h7FFF_FFFF;
    vals[3] = 32'h8000_0000; vals[4] = 32'hFFFF_FFFF; vals[5] = 32'h1234_5678;
    for (int i = 0; i < 64; i++) mem[i] = (i * 32'h0101_0101) ^ 32'h5A00_0000;

    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1", "rst_stack", a | b | c, 32'h0);
    chk("R1", "rst_flags", {29'd0, busy, mem_req, mem_we}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk_stack("R1");
    chk("R1", "post_flags", {29'd0, busy, mem_req, mem_we}, 32'h0);

    // R2: load constant sweep
    for (int i = 0; i < 16; i++) do_op(4'd1, 32'(i), "R2");
    do_op(4'd1, 32'hDEAD_BEEF, "R2");
    do_op(4'd1, 32'hFFFF_FFF0, "R2");

    // R3: load local sweep, R10 negative offset
    for (int i = 0; i < 16; i++) do_op(4'd2, 32'(i), "R3");
    do_op(4'd2, 32'hFFFF_FFFF, "R10");

    // R4: store local then read back
    for (int i = 0; i < 8; i++) begin
      do_op(4'd1, 32'hC000_0000 + 32'(i), "R4");
      do_op(4'd3, 32'(i + 4), "R4");
      do_op(4'd2, 32'(i + 4), "R4");
    end

    // R5: load non-local from several bases; R10 wrapped base
    for (int i = 0; i < 8; i++) begin
      do_op(4'd1, 32'h0000_0080, "R5");
      do_op(4'd4, 32'(i), "R5");
    end
    do_op(4'd1, 32'hFFFF_FFF0, "R10");
    do_op(4'd4, 32'd8, "R10");

    // R6: store non-local
    for (int i = 0; i < 6; i++) begin
      do_op(4'd1, 32'h0BAD_0000 + 32'(i), "R6");
      do_op(4'd1, 32'h5150_0000 + 32'(i), "R6");
      do_op(4'd1, 32'h0000_0040, "R6");
      do_op(4'd5, 32'(i), "R6");
      do_op(4'd2, 32'hFFFF_FFD0 + 32'(i), "R6");
    end

    // R7/R8: each operate code over ordered pairs of edge values
    for (int k = 0; k < 6; k++)
      for (int i = 0; i < 6; i++)
        for (int j = 0; j < 6; j++) begin
          do_op(4'd1, vals[i], k < 2 ? "R7" : "R8");
          do_op(4'd1, vals[j], k < 2 ? "R7" : "R8");
          do_op(4'd6, 32'(k), k < 2 ? "R7" : "R8");
        end

    // R10: addition wrap
    do_op(4'd1, 32'hFFFF_FFFF, "R10");
    do_op(4'd1, 32'd2, "R10");
    do_op(4'd6, 32'd0, "R10");
    chk("R10", "wrap_sum", a, 32'd1);

    // R9: unused function codes and operate codes have no effect
    do_op(4'd0, 32'd3, "R9");
    for (int f = 7; f < 16; f++) do_op(4'(f), 32'd1, "R9");
    for (int k = 6; k < 16; k++) do_op(4'd6, 32'(k), "R9");
    do_op(4'd6, 32'h8000_0000, "R9");

    // R9: issue during an outstanding read is dropped
    sa = ma; sb = mb;
    @(negedge clk);
    func = 4'd2; operand = 32'd3; issue = 1'b1;
    @(negedge clk);
    func = 4'd1; operand = 32'd9;
    @(negedge clk);
    chk("R9", "busy_hold", {31'd0, busy}, 32'd1);
    @(negedge clk);
    issue = 1'b0;
    chk("R9", "busy_done", {31'd0, busy}, 32'd0);
    chk("R9", "A_loaded", a, mem[(WS[7:2] + 6'd3)]);
    chk("R9", "B_shift", b, sa);
    chk("R9", "C_shift", c, sb);
    @(negedge clk);
    chk("R9", "no_late_push", a, mem[(WS[7:2] + 6'd3)]);
    chk("R9", "no_access", {30'd0, mem_we, mem_req}, 32'd0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule